// File: doc/BRIEF.md
# PHY Control-Register Port Write Sequencer

This block is the master side of a PHY's internal control-register port. Every access to that port is a four-phase exchange. The sequencer puts a 16-bit word on the data bus and raises exactly one command strobe. It then waits for the PHY acknowledge to rise, drops the strobe while holding the word, and waits for the acknowledge to fall. A register write chains three such exchanges: capture the address, capture the data, then issue the write command. Each wait is bounded by a count of microsecond ticks, and running out of ticks is treated as a failure.

After PHY initialisation, a one-cycle `cal_start` pulse launches a calibration run of three override writes in a fixed order:

1. The loss-of-signal detector override.
2. The transmit boost override.
3. The receiver-detect measurement time, whose value is taken from the reference-clock frequency code latched at start.

Software-style single writes can also be requested through an address/data/valid interface. `busy`, a one-cycle `done` pulse and a sticky `err` flag report progress and outcome.

Top module: `phy_crport_sequencer`

## Requirements
- R1: While reset is held and after its release, all three strobes, `rd_cmd`, `busy`, `done`, `err` and `phy_din` are zero.
- R2: At most one of `cap_addr`, `cap_data`, `wr_cmd` is high at any time. A strobe stays high until `phy_ack` is seen high and is removed on the following clock edge. The next strobe rises only after `phy_ack` has been seen low.
- R3: A write is exactly three exchanges in this order: `cap_addr` with the address on `phy_din`, then `cap_data` with the data, then `wr_cmd` with the same data.
- R4: `phy_din` holds its value from at least one cycle before a strobe rises until `phy_ack` has returned low.
- R5: Each wait for `phy_ack` high or low ends in a timeout after POLLS `us_tick` pulses. On timeout the strobe is dropped, the current transaction and any remaining calibration writes are abandoned, `err` is set, `done` pulses and the block returns to idle.
- R6: The first calibration write goes to address 0x0015 with data 0xA409. This is bias 5 in bits [15:13], override enable in bit 10 and level 9 in bits [4:0].
- R7: The second calibration write goes to address 0x0012 with data 0xA000, which is boost level 5 in bits [15:13].
- R8: The third calibration write goes to address 0x1010 with data equal to the measurement time shifted left by 4. The time is taken from `refclk_code` as follows:
  - codes 0 and 1 (19.2 and 20 MHz) give 0x4;
  - codes 2 to 4 (24, 25 and 26 MHz) give 0x8;
  - codes 5 to 8 (48, 50, 52 and 62.5 MHz) give 0x20;
  - codes 9 and 10 (96 and 100 MHz) give 0x40.
- R9: A `refclk_code` of 11 to 15 skips the third write and sets `err`. The first two writes are still issued.
- R10: `busy` is high from the cycle after a request is accepted until the run ends. `done` is high for exactly one cycle at the end of each accepted calibration run or single write, with `busy` already low.
- R11: `cal_start` and `wr_valid` have no effect while `busy` is high.
- R12: When idle, `wr_valid` starts one write of `wr_addr`/`wr_data`. If `cal_start` is high in the same cycle, the calibration run is taken and the single write is dropped.
- R13: `err` stays set after a run ends and is cleared only when a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| cal_start | input | 1 | Starts the calibration run when idle |
| refclk_code | input | CODE_W | Reference-clock frequency code (see R8) |
| wr_valid | input | 1 | Requests a single write when idle |
| wr_addr | input | 16 | Single-write register address |
| wr_data | input | 16 | Single-write data |
| phy_ack | input | 1 | PHY acknowledge |
| phy_din | output | 16 | Address/data bus to the PHY port |
| cap_addr | output | 1 | Address-capture strobe |
| cap_data | output | 1 | Data-capture strobe |
| wr_cmd | output | 1 | Write-command strobe |
| rd_cmd | output | 1 | Read-command strobe, held low |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky failure flag |

## Verification
The bench builds the sequencer with POLLS set to 8 and drives `us_tick` every fourth cycle. This keeps a full timeout near 32 cycles, so stalls in both the acknowledge-high and the acknowledge-low wait fit in short runs. With the same settings, an acknowledge delayed by six ticks is long but still legal. A PHY responder in the bench can stall either edge of any chosen exchange. This exercises aborting a calibration run partway through and clearing `err` afterwards. Every supported clock-code group and one unsupported code are run, each against a behavioural list of the expected exchanges.

// File: rtl/crport_pkg.sv
// Shared types for the PHY control-register port sequencer.
// Assumes a 16-bit port data field and three write-path command strobes.
package crport_pkg;
    localparam int DW      = 16;
    localparam int STROBES = 3;

    // Exchange kinds; the value is the strobe bit index.
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_DATA  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;
endpackage

// File: rtl/crport_refclk_decode.sv
// Maps the reference-clock code onto the receiver-detect measurement field.
// Assumes codes 0..10 are the supported frequency list; the rest are invalid.
module crport_refclk_decode
    import crport_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int SHIFT  = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic              valid,
    output logic [DW-1:0]     field
);
    logic [DW-1:0] meas;

    // Group the frequencies by shared measurement time.
    always_comb begin
        valid = 1'b1;
        meas  = '0;
        case (int'(code))
            0, 1:        meas = DW'(16'h0004);
            2, 3, 4:     meas = DW'(16'h0008);
            5, 6, 7, 8:  meas = DW'(16'h0020);
            9, 10:       meas = DW'(16'h0040);
            default:     valid = 1'b0;
        endcase
    end

    assign field = meas << SHIFT;
endmodule

// File: rtl/crport_handshake.sv
// One four-phase exchange: raise a strobe, wait ack high, drop strobe,
// wait ack low. Each wait is bounded by POLLS microsecond ticks.
// Assumes go is only asserted while the unit is idle.
module crport_handshake
    import crport_pkg::*;
#(
    parameter int POLLS = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               us_tick,
    input  logic               go,
    input  phase_e             kind,
    input  logic               phy_ack,
    output logic [STROBES-1:0] strb,
    output logic               ok,
    output logic               fail
);
    localparam int CW = $clog2(POLLS + 1);

    typedef enum logic [1:0] {H_IDLE, H_HI, H_LO} hs_state_e;
    hs_state_e     st;
    logic [CW-1:0] cnt;
    logic          last_poll;

    assign last_poll = (cnt == CW'(POLLS - 1));

    // Exchange state, strobe register and bounded poll counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= H_IDLE;
            cnt  <= '0;
            strb <= '0;
            ok   <= 1'b0;
            fail <= 1'b0;
        end else begin
            ok   <= 1'b0;
            fail <= 1'b0;
            case (st)
                H_IDLE: begin
                    if (go) begin
                        strb <= STROBES'(1) << kind;
                        cnt  <= '0;
                        st   <= H_HI;
                    end
                end
                H_HI: begin
                    if (phy_ack) begin
                        strb <= '0;
                        cnt  <= '0;
                        st   <= H_LO;
                    end else if (us_tick) begin
                        if (last_poll) begin
                            strb <= '0;
                            fail <= 1'b1;
                            st   <= H_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                H_LO: begin
                    if (!phy_ack) begin
                        ok <= 1'b1;
                        st <= H_IDLE;
                    end else if (us_tick) begin
                        if (last_poll) begin
                            fail <= 1'b1;
                            st   <= H_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= H_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crport_write_seq.sv
// Runs one register write as address capture, data capture, write command.
// Owns the data bus: it is loaded one cycle before each strobe and held
// until the exchange completes. Assumes req only while idle.
module crport_write_seq
    import crport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          hs_ok,
    input  logic          hs_fail,
    output logic [DW-1:0] bus,
    output logic          hs_go,
    output phase_e        hs_kind,
    output logic          wdone,
    output logic          wfail
);
    typedef enum logic [1:0] {W_IDLE, W_SETUP, W_WAIT} w_state_e;
    w_state_e      st;
    phase_e        phase;
    logic [DW-1:0] dlat;

    assign hs_go   = (st == W_SETUP);
    assign hs_kind = phase;

    // Phase ordering, bus loading and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= W_IDLE;
            phase <= PH_ADDR;
            bus   <= '0;
            dlat  <= '0;
            wdone <= 1'b0;
            wfail <= 1'b0;
        end else begin
            wdone <= 1'b0;
            wfail <= 1'b0;
            case (st)
                W_IDLE: begin
                    if (req) begin
                        bus   <= addr;
                        dlat  <= data;
                        phase <= PH_ADDR;
                        st    <= W_SETUP;
                    end
                end
                W_SETUP: st <= W_WAIT;
                W_WAIT: begin
                    if (hs_fail) begin
                        wfail <= 1'b1;
                        st    <= W_IDLE;
                    end else if (hs_ok) begin
                        case (phase)
                            PH_ADDR: begin
                                bus   <= dlat;
                                phase <= PH_DATA;
                                st    <= W_SETUP;
                            end
                            PH_DATA: begin
                                phase <= PH_WRITE;
                                st    <= W_SETUP;
                            end
                            default: begin
                                wdone <= 1'b1;
                                st    <= W_IDLE;
                            end
                        endcase
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phy_crport_sequencer.sv
// Top of the PHY control-register port sequencer: accepts a calibration
// start or a single write, steps through the calibration list, and reports
// busy / done / sticky error. Assumes us_tick is a one-cycle pulse.
module phy_crport_sequencer
    import crport_pkg::*;
#(
    parameter int POLLS     = 100,
    parameter int CODE_W    = 4,
    parameter int LOS_BIAS  = 5,
    parameter int LOS_LEVEL = 9,
    parameter int TX_BOOST  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              cal_start,
    input  logic [CODE_W-1:0] refclk_code,
    input  logic              wr_valid,
    input  logic [15:0]       wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              phy_ack,
    output logic [15:0]       phy_din,
    output logic              cap_addr,
    output logic              cap_data,
    output logic              wr_cmd,
    output logic              rd_cmd,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [DW-1:0] CAL0_ADDR = DW'(16'h0015);
    localparam logic [DW-1:0] CAL1_ADDR = DW'(16'h0012);
    localparam logic [DW-1:0] CAL2_ADDR = DW'(16'h1010);
    localparam logic [DW-1:0] CAL0_DATA =
        DW'((LOS_BIAS << 13) | (1 << 10) | LOS_LEVEL);
    localparam logic [DW-1:0] CAL1_DATA = DW'(TX_BOOST << 13);
    localparam int            LAST_IDX  = 2;

    typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} t_state_e;
    t_state_e          st;
    logic              cal_mode;
    logic [1:0]        idx;
    logic [CODE_W-1:0] code_q;
    logic [DW-1:0]     sa, sd;
    logic [DW-1:0]     req_addr, req_data;
    logic              skip_last, wreq;
    logic              dec_valid;
    logic [DW-1:0]     dec_field;
    logic              hs_go, hs_ok, hs_fail, wdone, wfail;
    phase_e            hs_kind;
    logic [STROBES-1:0] strb;

    crport_refclk_decode #(.CODE_W(CODE_W), .SHIFT(4)) dec_i (
        .code  (code_q),
        .valid (dec_valid),
        .field (dec_field)
    );

    // Select the address/data pair for the current request.
    always_comb begin
        req_addr = sa;
        req_data = sd;
        if (cal_mode) begin
            case (idx)
                2'd0:    begin req_addr = CAL0_ADDR; req_data = CAL0_DATA; end
                2'd1:    begin req_addr = CAL1_ADDR; req_data = CAL1_DATA; end
                default: begin req_addr = CAL2_ADDR; req_data = dec_field; end
            endcase
        end
    end

    assign skip_last = cal_mode && (idx == 2'(LAST_IDX)) && !dec_valid;
    assign wreq      = (st == T_ISSUE) && !skip_last;
    assign busy      = (st != T_IDLE);

    // Request acceptance, calibration stepping and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= T_IDLE;
            cal_mode <= 1'b0;
            idx      <= '0;
            code_q   <= '0;
            sa       <= '0;
            sd       <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                T_IDLE: begin
                    if (cal_start) begin
                        err      <= 1'b0;
                        cal_mode <= 1'b1;
                        idx      <= '0;
                        code_q   <= refclk_code;
                        st       <= T_ISSUE;
                    end else if (wr_valid) begin
                        err      <= 1'b0;
                        cal_mode <= 1'b0;
                        sa       <= wr_addr;
                        sd       <= wr_data;
                        st       <= T_ISSUE;
                    end
                end
                T_ISSUE: begin
                    if (skip_last) begin
                        err  <= 1'b1;
                        done <= 1'b1;
                        st   <= T_IDLE;
                    end else begin
                        st <= T_WAIT;
                    end
                end
                T_WAIT: begin
                    if (wfail) begin
                        err  <= 1'b1;
                        done <= 1'b1;
                        st   <= T_IDLE;
                    end else if (wdone) begin
                        if (cal_mode && idx != 2'(LAST_IDX)) begin
                            idx <= idx + 1'b1;
                            st  <= T_ISSUE;
                        end else begin
                            done <= 1'b1;
                            st   <= T_IDLE;
                        end
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    crport_write_seq wseq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (wreq),
        .addr    (req_addr),
        .data    (req_data),
        .hs_ok   (hs_ok),
        .hs_fail (hs_fail),
        .bus     (phy_din),
        .hs_go   (hs_go),
        .hs_kind (hs_kind),
        .wdone   (wdone),
        .wfail   (wfail)
    );

    crport_handshake #(.POLLS(POLLS)) hs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .go      (hs_go),
        .kind    (hs_kind),
        .phy_ack (phy_ack),
        .strb    (strb),
        .ok      (hs_ok),
        .fail    (hs_fail)
    );

    assign cap_addr = strb[PH_ADDR];
    assign cap_data = strb[PH_DATA];
    assign wr_cmd   = strb[PH_WRITE];
    assign rd_cmd   = 1'b0;
endmodule

// File: rtl/phy_crport_sequencer_chk.sv
// Property checker for the port sequencer, attached through bind.
// Assumes us_tick pulses for one cycle; watches ports only.
module phy_crport_sequencer_chk #(
    parameter int POLLS = 100
) (
    input logic        clk,
    input logic        rst_n,
    input logic        us_tick,
    input logic        phy_ack,
    input logic [15:0] phy_din,
    input logic        cap_addr,
    input logic        cap_data,
    input logic        wr_cmd,
    input logic        busy,
    input logic        done
);
    logic [2:0]  s;
    int unsigned wait_ticks;

    assign s = {wr_cmd, cap_data, cap_addr};

    // Count ticks spent with a strobe up and no acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wait_ticks <= 0;
        else if (s != 3'b0 && !phy_ack) begin
            if (us_tick)             wait_ticks <= wait_ticks + 1;
        end else                     wait_ticks <= 0;
    end

    assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s));
    assert_strobe_drop_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s != 3'b0 && phy_ack) |=> (s == 3'b0));
    assert_bus_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s != 3'b0 && $past(s) == 3'b0) |-> $stable(phy_din));
    assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s != 3'b0) |=> $stable(phy_din));
    assert_wait_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_ticks <= POLLS);
    assert_idle_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (s == 3'b0));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind phy_crport_sequencer phy_crport_sequencer_chk #(.POLLS(POLLS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .phy_ack  (phy_ack),
    .phy_din  (phy_din),
    .cap_addr (cap_addr),
    .cap_data (cap_data),
    .wr_cmd   (wr_cmd),
    .busy     (busy),
    .done     (done)
);

// File: tb/phy_crport_sequencer_tb_top.sv
// Bench: PHY responder model, behavioural list of expected exchanges,
// per-clock monitor of strobe/bus rules, and directed scenarios.
module phy_crport_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int POLLS_TB   = 8;
    localparam int TICK_DIV   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        cal_start = 1'b0;
    logic [3:0]  refclk_code = '0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0, wr_data = '0;
    logic        phy_ack;
    logic [15:0] phy_din;
    logic        cap_addr, cap_data, wr_cmd, rd_cmd, busy, done, err;

    int checks = 0, errors = 0, cycles = 0;
    logic [18:0] obs[$];
    logic [18:0] exp_q[$];
    int hang_kind = 0, hang_at = 0, ack_delay = 2;
    int done_cnt = 0;
    logic err_at_done = 1'b0;
    int hi_run = 0, last_hi_run = 0;
    logic [2:0]  prev_s = '0;
    logic [15:0] prev_bus = '0;
    logic        prev_in = 1'b0, prev_done = 1'b0;
    int tick_cnt = 0;

    phy_crport_sequencer #(.POLLS(POLLS_TB)) dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cal_start(cal_start),
        .refclk_code(refclk_code), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .phy_ack(phy_ack), .phy_din(phy_din),
        .cap_addr(cap_addr), .cap_data(cap_data), .wr_cmd(wr_cmd),
        .rd_cmd(rd_cmd), .busy(busy), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Microsecond tick every TICK_DIV cycles, driven away from the edge.
    always @(negedge clk) begin
        tick_cnt <= (tick_cnt + 1) % TICK_DIV;
        us_tick  <= (tick_cnt == TICK_DIV - 1);
    end

    // PHY responder with optional stall of either acknowledge edge.
    int dcnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            phy_ack <= 1'b0;
            dcnt    <= 0;
        end else begin
            automatic int cur = obs.size() - 1;
            automatic logic [2:0] s = {wr_cmd, cap_data, cap_addr};
            if (s != 3'b0 && !phy_ack) begin
                if (!(hang_kind == 1 && cur == hang_at)) begin
                    if (dcnt >= ack_delay) begin phy_ack <= 1'b1; dcnt <= 0; end
                    else dcnt <= dcnt + 1;
                end
            end else if (s == 3'b0 && phy_ack) begin
                if (!(hang_kind == 2 && cur == hang_at)) begin
                    if (dcnt >= ack_delay) begin phy_ack <= 1'b0; dcnt <= 0; end
                    else dcnt <= dcnt + 1;
                end
            end else begin
                dcnt <= 0;
            end
        end
    end

    task automatic fail_msg(input string req, input string what,
                            input longint act, input longint expv);
        errors++;
        $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    endtask

    // Monitor: records exchanges, checks one-hot, bus stability, done width.
    always @(negedge clk) begin
        automatic logic [2:0] s = {wr_cmd, cap_data, cap_addr};
        cycles++;
        if (rst_n) begin
            if ($countones(s) > 1) fail_msg("R2", "strobes not one-hot", s, 0);
            if (s != 3'b0 && prev_s == 3'b0) obs.push_back({s, phy_din});
            if (prev_in && (s != 3'b0 || phy_ack) && phy_din != prev_bus)
                fail_msg("R4", "bus moved in exchange", phy_din, prev_bus);
            if (s != 3'b0) hi_run++;
            else if (prev_s != 3'b0) begin last_hi_run = hi_run; hi_run = 0; end
            if (done) begin
                done_cnt++;
                err_at_done = err;
                if (busy) fail_msg("R10", "busy with done", busy, 0);
                if (prev_done) fail_msg("R10", "done wider than 1", 1, 0);
            end
        end
        prev_s    = s;
        prev_bus  = phy_din;
        prev_in   = (s != 3'b0) || (phy_ack && prev_in);
        prev_done = done;
        if (cycles > 150000) begin
            fail_msg("WDOG", "watchdog expired", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit c, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!c) fail_msg(req, what, act, expv);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cal_start = 0; wr_valid = 0; hang_kind = 0; ack_delay = 2;
        repeat (3) @(negedge clk);
        obs.delete(); exp_q.delete(); done_cnt = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_write(input logic [15:0] a, input logic [15:0] d);
        exp_q.push_back({3'b001, a});
        exp_q.push_back({3'b010, d});
        exp_q.push_back({3'b100, d});
    endtask

    task automatic push_cal(input int meas);
        push_write(16'h0015, 16'hA409);   // R6
        push_write(16'h0012, 16'hA000);   // R7
        if (meas >= 0) push_write(16'h1010, 16'(meas << 4)); // R8
    endtask

    task automatic wait_done(input int n);
        automatic int k = 0;
        while (done_cnt < n && k < 5000) begin @(negedge clk); k++; end
        chk(done_cnt >= n, "R10", "done not seen", done_cnt, n);
    endtask

    task automatic compare(input string req);
        chk(obs.size() == exp_q.size(), req, "exchange count", obs.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < obs.size(); i++)
            chk(obs[i] == exp_q[i], req, $sformatf("exchange %0d", i), obs[i], exp_q[i]);
    endtask

    task automatic pulse_cal(input logic [3:0] code);
        @(negedge clk); cal_start = 1; refclk_code = code;
        @(negedge clk); cal_start = 0;
    endtask

    task automatic pulse_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_valid = 0;
    endtask

    task automatic run_cal(input logic [3:0] code, input int meas, input string req);
        do_reset();
        push_cal(meas);
        pulse_cal(code);
        chk(busy, "R10", "busy after accept", busy, 1);
        wait_done(1);
        compare(req);
        chk(err_at_done == (meas < 0), req, "err at done", err_at_done, meas < 0);
    endtask

    initial begin
        // R1 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({cap_addr, cap_data, wr_cmd, rd_cmd, busy, done, err} == 7'b0 && phy_din == 0,
            "R1", "outputs in reset", {cap_addr, cap_data, wr_cmd, busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phy_din == 0 && !busy && !err, "R1", "outputs after reset", phy_din, 0);

        // R3 R6 R7 R8 calibration per clock group
        run_cal(4'd0,  4,    "R8");
        run_cal(4'd1,  4,    "R8");
        run_cal(4'd3,  8,    "R8");
        run_cal(4'd7,  32,   "R8");
        run_cal(4'd8,  32,   "R8");
        run_cal(4'd10, 64,   "R8");
        run_cal(4'd9,  64,   "R6");
        // R9 unsupported code
        run_cal(4'd12, -1,   "R9");

        // R12 single write, R3 ordering
        do_reset();
        push_write(16'h1234, 16'hBEEF);
        pulse_wr(16'h1234, 16'hBEEF);
        wait_done(1);
        compare("R3");
        chk(!err_at_done, "R12", "err after single write", err_at_done, 0);

        // R12 priority: cal_start wins over wr_valid
        do_reset();
        push_cal(8);
        @(negedge clk); cal_start = 1; wr_valid = 1; refclk_code = 4'd2;
        wr_addr = 16'h5555; wr_data = 16'h6666;
        @(negedge clk); cal_start = 0; wr_valid = 0;
        wait_done(1);
        compare("R12");

        // R11 requests ignored while busy
        do_reset();
        push_cal(4);
        pulse_cal(4'd0);
        repeat (10) @(negedge clk);
        @(negedge clk); cal_start = 1; wr_valid = 1; refclk_code = 4'd9;
        wr_addr = 16'h7777; wr_data = 16'h8888;
        @(negedge clk); cal_start = 0; wr_valid = 0;
        wait_done(1);
        repeat (40) @(negedge clk);
        compare("R11");
        chk(done_cnt == 1, "R11", "extra done", done_cnt, 1);

        // R2 slow acknowledge inside the limit
        do_reset();
        ack_delay = 24;
        push_write(16'h0042, 16'h0099);
        pulse_wr(16'h0042, 16'h0099);
        wait_done(1);
        compare("R2");
        chk(!err_at_done, "R2", "slow ack flagged", err_at_done, 0);

        // R5 no acknowledge on single write: bounded strobe, abort
        do_reset();
        hang_kind = 1; hang_at = 0;
        exp_q.push_back({3'b001, 16'h0300});
        pulse_wr(16'h0300, 16'h0400);
        wait_done(1);
        compare("R5");
        chk(err_at_done, "R5", "err after timeout", err_at_done, 1);
        chk(last_hi_run >= (POLLS_TB - 1) * TICK_DIV && last_hi_run <= POLLS_TB * TICK_DIV + 1,
            "R5", "strobe length at timeout", last_hi_run, POLLS_TB * TICK_DIV);
        chk(!busy && {cap_addr, cap_data, wr_cmd} == 0, "R5", "idle after timeout", busy, 0);
        // R13 err sticky, then cleared by a new request
        repeat (20) @(negedge clk);
        chk(err, "R13", "err held", err, 1);
        hang_kind = 0;
        obs.delete(); exp_q.delete();
        push_write(16'h0001, 16'h0002);
        pulse_wr(16'h0001, 16'h0002);
        chk(!err, "R13", "err cleared on accept", err, 0);
        wait_done(2);
        compare("R13");

        // R5 acknowledge stuck high in the 2nd write: rest of run abandoned
        do_reset();
        hang_kind = 2; hang_at = 3;
        push_cal(4);
        while (exp_q.size() > 4) void'(exp_q.pop_back());
        pulse_cal(4'd1);
        wait_done(1);
        repeat (60) @(negedge clk);
        compare("R5");
        chk(err_at_done && done_cnt == 1, "R5", "abort with err", err_at_done, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule